// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block gathers three kinds of per-channel event pulses from a DMA engine of up to sixteen channels and turns them into a single level interrupt. The three kinds are half-transfer, descriptor done and queue done. Each channel owns one 4-bit group of a 32-bit register. Bit 0 of the group is half-transfer, bit 1 is descriptor done, bit 2 is queue done, and bit 3 is reserved. Channels 0 to 7 sit in the lower register of a pair and channels 8 to 15 in the upper one. There is one pair of enable registers and one pair of pending registers.

An event pulse latches its pending bit regardless of the enable setting. Software acknowledges events by writing ones to pending bits. The interrupt output is a registered OR over every pending bit whose enable bit is also set. A read-only status word reports which channels are busy.

The register port is a plain 32-bit write strobe with address and data, and a combinational read of the addressed register. There is no streamed data at this block's edge, so no valid/ready handshake is used.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, both enable registers and both pending registers read zero, and `irq` is low.
- R2: An event pulse of kind k on channel n sets the pending bit at position (n mod 8)*4+k on the following clock edge. Kind k is 0 for half-transfer, 1 for descriptor done and 2 for queue done. Channels below 8 use the pending register at offset 0x10, and the others use offset 0x14.
- R3: A pending bit is set by its event even while its enable bit is zero.
- R4: Writing ones to a pending register clears exactly those bits. Writing zero changes nothing. Writing 0xFFFFFFFF clears every pending bit of that register.
- R5: If an event and a write-one-to-clear reach the same pending bit in the same cycle, the bit stays set.
- R6: The enable registers at offsets 0x00 (channels 0 to 7) and 0x04 (channels 8 to 15) read back the written value, with bit 3 of every group forced to zero.
- R7: Bit 3 of every pending group always reads zero. A write to a pending register never sets a bit.
- R8: `irq` is high one clock after some pending bit and its enable bit are both set, and low one clock after no such pair remains.
- R9: The status word at offset 0x30 shows `ch_busy` in bits NUM_CH-1:0 and zero above.
- R10: A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| ev_half | input | NUM_CH | Half-transfer event pulses, one per channel |
| ev_pkg | input | NUM_CH | Descriptor-done event pulses |
| ev_queue | input | NUM_CH | Queue-done event pulses |
| ch_busy | input | NUM_CH | Busy level of each channel |
| irq | output | 1 | Level interrupt |

## Verification
A walking single event is swept over every channel and every event kind. Each step checks that exactly one pending bit is set in the correct register, which separates errors in channel-to-register placement from errors in kind-to-bit placement. The same sweep then enables only that bit, and then clears it with a zero write followed by a one write. This checks the interrupt timing and shows that a zero write differs from a one write. Dedicated patterns cover the rest: an event that collides with a clear, all-ones writes to the enable and pending registers (which exercise the reserved bits and clear-all), an irregular busy pattern, and reads of unmapped offsets.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W      = 32;
  localparam int GRP_W      = 4;
  localparam int CH_PER_REG = REG_W / GRP_W;
  localparam int MAX_CH     = 2 * CH_PER_REG;

  localparam int K_HALF  = 0;
  localparam int K_PKG   = 1;
  localparam int K_QUEUE = 2;

  localparam logic [7:0] OFS_EN_LO   = 8'h00;
  localparam logic [7:0] OFS_EN_HI   = 8'h04;
  localparam logic [7:0] OFS_PEND_LO = 8'h10;
  localparam logic [7:0] OFS_PEND_HI = 8'h14;
  localparam logic [7:0] OFS_STATUS  = 8'h30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_PEND_LO,
    SEL_PEND_HI,
    SEL_STATUS
  } reg_sel_e;

  // bits that exist for the first nch channels of one register
  function automatic logic [REG_W-1:0] live_mask(input int nch);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < CH_PER_REG; c++) begin
      if (c < nch) m[c*GRP_W +: GRP_W] = 4'b0111;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_EN_LO))        sel = SEL_EN_LO;
    else if (addr == ADDR_W'(OFS_EN_HI))   sel = SEL_EN_HI;
    else if (addr == ADDR_W'(OFS_PEND_LO)) sel = SEL_PEND_LO;
    else if (addr == ADDR_W'(OFS_PEND_HI)) sel = SEL_PEND_HI;
    else if (addr == ADDR_W'(OFS_STATUS))  sel = SEL_STATUS;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int LIVE_CH = CH_PER_REG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_we,
  input  logic                  pend_we,
  input  logic [REG_W-1:0]      wdata,
  input  logic [CH_PER_REG-1:0] ev_half,
  input  logic [CH_PER_REG-1:0] ev_pkg,
  input  logic [CH_PER_REG-1:0] ev_queue,
  output logic [REG_W-1:0]      en_q,
  output logic [REG_W-1:0]      pend_q,
  output logic                  hit
);
  localparam logic [REG_W-1:0] LIVE = live_mask(LIVE_CH);

  logic [REG_W-1:0] ev_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] pend_d;

  for (genvar c = 0; c < CH_PER_REG; c++) begin : g_grp
    assign ev_vec[c*GRP_W + K_HALF]  = ev_half[c];
    assign ev_vec[c*GRP_W + K_PKG]   = ev_pkg[c];
    assign ev_vec[c*GRP_W + K_QUEUE] = ev_queue[c];
    assign ev_vec[c*GRP_W + 3]       = 1'b0;
  end

  assign clr_vec = pend_we ? wdata : '0;
  // a new event outranks a clear in the same cycle
  assign pend_d  = ((pend_q & ~clr_vec) | ev_vec) & LIVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= wdata & LIVE;
    end
  end

  assign hit = |(pend_q & en_q);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_pkg,
  input  logic [NUM_CH-1:0] ev_queue,
  input  logic [NUM_CH-1:0] ch_busy,
  output logic              irq
);
  localparam int NUM_BANK = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;
  localparam int PAD_CH   = 2 * CH_PER_REG;

  reg_sel_e sel;
  logic [PAD_CH-1:0] half_pad, pkg_pad, queue_pad;
  logic [1:0][REG_W-1:0] en_r, pend_r;
  logic [1:0] hit_r;
  logic [2*REG_W-1:0] pend_all, en_all;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  assign half_pad  = PAD_CH'(ev_half);
  assign pkg_pad   = PAD_CH'(ev_pkg);
  assign queue_pad = PAD_CH'(ev_queue);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b < NUM_BANK) begin : g_live
      localparam int LC = (NUM_CH - b*CH_PER_REG > CH_PER_REG) ?
                          CH_PER_REG : NUM_CH - b*CH_PER_REG;
      dma_irq_bank #(.LIVE_CH(LC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (reg_we && (sel == (b == 0 ? SEL_EN_LO : SEL_EN_HI))),
        .pend_we  (reg_we && (sel == (b == 0 ? SEL_PEND_LO : SEL_PEND_HI))),
        .wdata    (reg_wdata),
        .ev_half  (half_pad[b*CH_PER_REG +: CH_PER_REG]),
        .ev_pkg   (pkg_pad[b*CH_PER_REG +: CH_PER_REG]),
        .ev_queue (queue_pad[b*CH_PER_REG +: CH_PER_REG]),
        .en_q     (en_r[b]),
        .pend_q   (pend_r[b]),
        .hit      (hit_r[b])
      );
    end else begin : g_absent
      assign en_r[b]   = '0;
      assign pend_r[b] = '0;
      assign hit_r[b]  = 1'b0;
    end
  end

  assign pend_all = {pend_r[1], pend_r[0]};
  assign en_all   = {en_r[1], en_r[0]};

  always_comb begin
    unique case (sel)
      SEL_EN_LO:   reg_rdata = en_r[0];
      SEL_EN_HI:   reg_rdata = en_r[1];
      SEL_PEND_LO: reg_rdata = pend_r[0];
      SEL_PEND_HI: reg_rdata = pend_r[1];
      SEL_STATUS:  reg_rdata = 32'(ch_busy);
      default:     reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |hit_r;
  end
endmodule

// File: rtl/dma_irq_checker.sv
module dma_irq_checker
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [NUM_CH-1:0] ev_half,
  input logic [NUM_CH-1:0] ev_pkg,
  input logic [NUM_CH-1:0] ev_queue,
  input logic [NUM_CH-1:0] ch_busy,
  input logic [63:0]       pend_all,
  input logic [63:0]       en_all,
  input logic              irq
);
  localparam logic [63:0] RSV = 64'h8888_8888_8888_8888;
  logic [63:0] ev_all;

  for (genvar n = 0; n < MAX_CH; n++) begin : g_ev
    if (n < NUM_CH) begin : g_on
      assign ev_all[n*4 +: 4] = {1'b0, ev_queue[n], ev_pkg[n], ev_half[n]};
    end else begin : g_off
      assign ev_all[n*4 +: 4] = 4'b0;
    end
  end

  assert_event_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((pend_all & $past(ev_all)) == $past(ev_all)));

  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((pend_all & ~$past(pend_all) & ~$past(ev_all)) == 64'd0));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_all | en_all) & RSV) == 64'd0);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (irq == $past(|(pend_all & en_all))));

  assert_status_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_STATUS)) |-> (reg_rdata == 32'(ch_busy)));
endmodule

bind dma_irq_ctrl dma_irq_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .ev_half   (ev_half),
  .ev_pkg    (ev_pkg),
  .ev_queue  (ev_queue),
  .ch_busy   (ch_busy),
  .pend_all  (pend_all),
  .en_all    (en_all),
  .irq       (irq)
);

// File: tb/test_dma_irq_ctrl.sv
module test_dma_irq_ctrl;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] ev_half = '0, ev_pkg = '0, ev_queue = '0, ch_busy = '0;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(8)) i_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_half(ev_half),
    .ev_pkg(ev_pkg), .ev_queue(ev_queue), .ch_busy(ch_busy), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input int ch, input int k);
    case (k)
      0: ev_half[ch] = 1'b1;
      1: ev_pkg[ch] = 1'b1;
      default: ev_queue[ch] = 1'b1;
    endcase
    step();
    ev_half = '0; ev_pkg = '0; ev_queue = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd(8'h00, d); chk("R1 en lo", d, 32'h0);
    rd(8'h04, d); chk("R1 en hi", d, 32'h0);
    rd(8'h10, d); chk("R1 pend lo", d, 32'h0);
    rd(8'h14, d); chk("R1 pend hi", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // sweep every channel and kind
    for (int ch = 0; ch < NCH; ch++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] pa, oa, ea;
        logic [31:0] bitv;
        pa = (ch < 8) ? 8'h10 : 8'h14;
        oa = (ch < 8) ? 8'h14 : 8'h10;
        ea = (ch < 8) ? 8'h00 : 8'h04;
        bitv = 32'd1 << ((ch % 8) * 4 + k);
        pulse(ch, k);
        rd(pa, d); chk("R2 R3 pending placement", d, bitv);
        rd(oa, d); chk("R2 other register untouched", d, 32'h0);
        step();
        chk("R3 R8 masked irq", {31'd0, irq}, 32'h0);
        wr(ea, bitv);
        chk("R8 irq latency", {31'd0, irq}, 32'h0);
        step();
        chk("R8 irq raised", {31'd0, irq}, 32'h1);
        wr(pa, 32'h0);
        rd(pa, d); chk("R4 zero write no effect", d, bitv);
        wr(pa, bitv);
        rd(pa, d); chk("R4 one clears", d, 32'h0);
        chk("R8 irq held one cycle", {31'd0, irq}, 32'h1);
        step();
        chk("R8 irq dropped", {31'd0, irq}, 32'h0);
        wr(ea, 32'h0);
      end
    end

    // R5 event and clear collide
    pulse(3, 1);
    ev_pkg[3] = 1'b1;
    wr(8'h10, 32'h0000_2000);
    ev_pkg = '0;
    rd(8'h10, d); chk("R5 event beats clear", d, 32'h0000_2000);
    wr(8'h10, 32'hFFFF_FFFF);

    // R6 enable readback with reserved bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R6 en lo mask", d, 32'h7777_7777);
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, d); chk("R6 en hi mask", d, 32'h1234_5670);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);

    // R7 writes cannot set pending
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R7 no set lo", d, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R7 no set hi", d, 32'h0);

    // R4 clear-all with many bits set
    ev_half = 16'hFFFF; ev_pkg = 16'hFFFF; ev_queue = 16'hFFFF;
    step();
    ev_half = '0; ev_pkg = '0; ev_queue = '0;
    rd(8'h10, d); chk("R2 R7 all lo", d, 32'h7777_7777);
    rd(8'h14, d); chk("R2 R7 all hi", d, 32'h7777_7777);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R4 clear all lo", d, 32'h0);
    rd(8'h14, d); chk("R4 clear all hi", d, 32'h0);

    // R9 status
    ch_busy = 16'hA5C3;
    rd(8'h30, d); chk("R9 status", d, 32'h0000_A5C3);
    ch_busy = 16'h0001;
    rd(8'h30, d); chk("R9 status single", d, 32'h0000_0001);

    // R10 unmapped reads
    ev_half = 16'h0001; step(); ev_half = '0;
    rd(8'h08, d); chk("R10 offset 08", d, 32'h0);
    rd(8'h20, d); chk("R10 offset 20", d, 32'h0);
    rd(8'h34, d); chk("R10 offset 34", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule